// File: doc/BRIEF.md
# Paired-Slot Microprogram Sequencer Control

This block steers a small coprocessor that runs code from a local micro-memory one 64-bit pair per clock. Each pair carries an upper instruction in bits 63:32 and a lower instruction in bits 31:0. The sequencer owns the program counter and reads four control flags from the upper word. It runs branch delay slots, including a second branch placed inside a delay slot. It counts down to the end of a program and raises a one-cycle interrupt request when an enabled debug or trap flag stops execution. The opcode decoders, register files and arithmetic units sit outside. They hand the sequencer a branch decision with its target and the register indexes each slot uses. In return the sequencer tells them which slots may act this cycle and how same-pair register conflicts resolve.

The micro-memory is read asynchronously: `fetch_data_i` must hold the pair addressed by `fetch_addr_o` within the same cycle. A pulse on `start_i` while the block is idle loads the start address and sets the running bit. The pair at that address issues on the next cycle, and one pair follows per cycle after that.

The controller has three states. **IDLE**: nothing issues, and only `start_i` is accepted (transition *launch*, IDLE to RUN). **RUN**: one pair issues every cycle. When the end countdown expires, RUN goes to IDLE (transition *finish*), or to DRAIN if a branch countdown is still pending (transition *finish-pending*). **DRAIN**: exactly one more pair issues with the running bit already clear, then the state returns to IDLE (transition *drain-done*).

Top module: `useq_ctrl`

## Requirements
- R1: While the running bit (`status_o[0]`) is set, a pair issues every cycle (`up_valid_o` high) at `fetch_addr_o`. With no branch applying, the next address is the current one plus 8.
- R2: Every next address and the start address are ANDed with `PC_MASK`, so the counter wraps from the last pair of the memory to address 0, and low address bits given at start are dropped.
- R3: Upper-word bit 30 (end flag) lets exactly one further pair issue. After that pair the running bit clears and nothing more issues.
- R4: Upper-word bit 28 (debug flag) with `dbg_en_i` high sets `status_o[1]`, pulses `irq_o` for one cycle in the cycle after that pair issues, and stops execution after that pair. With `dbg_en_i` low the flag has no effect.
- R5: Upper-word bit 27 (trap flag) with `trap_en_i` high sets `status_o[2]`, pulses `irq_o` in the following cycle, and stops after that pair. With `trap_en_i` low the flag has no effect.
- R6: Upper-word bit 31 (immediate flag) keeps `up_valid_o` high, holds `lo_valid_o` low, and raises `imm_load_o` with `imm_data_o` equal to the lower word. A branch request in that pair is ignored.
- R7: A taken lower-slot branch has one delay slot. The pair after the branch issues, and then the target issues.
- R8: A branch taken inside a delay slot is deferred. The first target issues, then the pair after it, and then the second target.
- R9: When both slots name the same nonzero write index, `lo_wr_kill_o` is raised with `lo_valid_o`. Index 0 means no write and never conflicts.
- R10: `lo_rd_old_o[k]` is high when lower read port k names the upper slot's nonzero write index. That port must then see the value from before the upper write.
- R11: If execution stops while a branch countdown is still pending, exactly one more pair issues with the running bit clear. No pair issues after it.
- R12: Reset clears the state, countdowns, status and outputs. `start_i` acts only in IDLE: it sets the running bit and clears the debug and trap bits, and is ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin execution (accepted in IDLE only) |
| start_pc_i | input | ADDR_W | Start byte address |
| dbg_en_i | input | 1 | Enables the debug flag |
| trap_en_i | input | 1 | Enables the trap flag |
| fetch_addr_o | output | ADDR_W | Byte address of the current pair |
| fetch_data_i | input | 64 | Pair read at `fetch_addr_o` (upper 63:32, lower 31:0) |
| br_take_i | input | 1 | Lower slot requests a taken branch this pair |
| br_tgt_i | input | ADDR_W | Branch target byte address |
| up_wr_idx_i | input | IDX_W | Upper slot write index (0 = none) |
| lo_wr_idx_i | input | IDX_W | Lower slot write index (0 = none) |
| lo_rd_idx_i | input | RD_PORTS*IDX_W | Lower slot read indexes, port k at bits k*IDX_W upward |
| up_valid_o | output | 1 | Upper slot executes this cycle |
| lo_valid_o | output | 1 | Lower slot executes this cycle |
| lo_wr_kill_o | output | 1 | Lower slot write suppressed |
| lo_rd_old_o | output | RD_PORTS | Lower read port k takes the pre-write value |
| imm_load_o | output | 1 | Load the immediate register |
| imm_data_o | output | 32 | Immediate value |
| irq_o | output | 1 | Interrupt request pulse |
| status_o | output | 3 | {trap stop, debug stop, running} |

## Verification
The situation hardest to reach from the ports is a stop that lands while a branch is still counting down, because the block must then issue one pair with the running bit already clear. The bench places the end flag one pair ahead of a taken branch, so the countdown expires in the delay slot, and checks that the branch's delay slot issues and its target does not. A branch inside a delay slot is also reached only through a precise program layout. The bench places two taken branches back to back and follows the issued address trace through both targets.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } useq_state_e;

    // flag bit positions inside the upper instruction word
    localparam int unsigned FLG_IMM  = 31;
    localparam int unsigned FLG_END  = 30;
    localparam int unsigned FLG_DBG  = 28;
    localparam int unsigned FLG_TRAP = 27;

    // status bit positions
    localparam int unsigned STAT_RUN  = 0;
    localparam int unsigned STAT_DBG  = 1;
    localparam int unsigned STAT_TRAP = 2;

    typedef struct packed {
        logic imm;
        logic fin;
        logic dbg;
        logic trap;
    } up_flags_t;

endpackage

// File: rtl/useq_flag_decode.sv
module useq_flag_decode
    import useq_pkg::*;
(
    input  logic [31:0] up_word,
    input  logic        issue,
    input  logic        dbg_en,
    input  logic        trap_en,
    output up_flags_t   flags,
    output logic        dbg_hit,
    output logic        trap_hit
);

    logic unused_up_bits;

    always_comb begin
        flags.imm  = up_word[FLG_IMM];
        flags.fin  = up_word[FLG_END];
        flags.dbg  = up_word[FLG_DBG];
        flags.trap = up_word[FLG_TRAP];
        dbg_hit    = issue & flags.dbg & dbg_en;
        trap_hit   = issue & flags.trap & trap_en;
    end

    assign unused_up_bits = ^{up_word[29], up_word[26:0]};

endmodule

// File: rtl/useq_slot_check.sv
module useq_slot_check #(
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned RD_PORTS = 2
) (
    input  logic                      issue,
    input  logic                      imm,
    input  logic [IDX_W-1:0]          up_wr_idx,
    input  logic [IDX_W-1:0]          lo_wr_idx,
    input  logic [RD_PORTS*IDX_W-1:0] lo_rd_idx,
    output logic                      lo_valid,
    output logic                      lo_wr_kill,
    output logic [RD_PORTS-1:0]       lo_rd_old
);

    logic up_writes;

    assign up_writes  = (up_wr_idx != '0);
    assign lo_valid   = issue & ~imm;
    assign lo_wr_kill = lo_valid & up_writes & (lo_wr_idx == up_wr_idx);

    for (genvar k = 0; k < RD_PORTS; k++) begin : g_rd
        assign lo_rd_old[k] = lo_valid & up_writes
                            & (lo_rd_idx[k*IDX_W +: IDX_W] == up_wr_idx);
    end

endmodule

// File: rtl/useq_branch_ctl.sv
module useq_branch_ctl #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              issue,
    input  logic              take,
    input  logic [ADDR_W-1:0] tgt,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              pend_next
);

    logic [1:0]        cnt_q,  cnt_a,  cnt_n;
    logic [ADDR_W-1:0] bpc_q,  bpc_a,  bpc_n;
    logic              dly_q,  dly_a,  dly_n;
    logic [ADDR_W-1:0] dpc_q,  dpc_a,  dpc_n;
    logic              apply;

    always_comb begin
        cnt_a = cnt_q;
        bpc_a = bpc_q;
        dly_a = dly_q;
        dpc_a = dpc_q;
        if (take) begin
            if (cnt_q == 2'd0) begin
                cnt_a = 2'd2;
                bpc_a = tgt;
            end else begin
                dly_a = 1'b1;
                dpc_a = tgt;
            end
        end
        cnt_n = cnt_a;
        bpc_n = bpc_a;
        dly_n = dly_a;
        dpc_n = dpc_a;
        apply = 1'b0;
        if (cnt_a != 2'd0) begin
            cnt_n = cnt_a - 2'd1;
            if (cnt_a == 2'd1) begin
                apply = 1'b1;
                if (dly_a) begin
                    cnt_n = 2'd2;
                    bpc_n = dpc_a;
                    dly_n = 1'b0;
                end
            end
        end
    end

    assign redirect    = issue & apply;
    assign redirect_pc = bpc_a;
    assign pend_next   = (cnt_n != 2'd0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            bpc_q <= '0;
            dly_q <= 1'b0;
            dpc_q <= '0;
        end else if (issue) begin
            cnt_q <= cnt_n;
            bpc_q <= bpc_n;
            dly_q <= dly_n;
            dpc_q <= dpc_n;
        end
    end

endmodule

// File: rtl/useq_end_ctl.sv
module useq_end_ctl (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic issue,
    input  logic fin,
    input  logic halt,
    output logic expire
);

    logic [1:0] cnt_q, cnt_a, cnt_n;

    always_comb begin
        cnt_a = cnt_q;
        if (fin)  cnt_a = 2'd2;
        if (halt) cnt_a = 2'd1;
        cnt_n = (cnt_a != 2'd0) ? cnt_a - 2'd1 : 2'd0;
    end

    assign expire = issue & (cnt_a == 2'd1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (issue) begin
            cnt_q <= cnt_n;
        end
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 14,
    parameter logic [ADDR_W-1:0] PC_MASK  = {{(ADDR_W-3){1'b1}}, 3'b000},
    parameter int unsigned       IDX_W    = 5,
    parameter int unsigned       RD_PORTS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         start_pc_i,
    input  logic                      dbg_en_i,
    input  logic                      trap_en_i,
    output logic [ADDR_W-1:0]         fetch_addr_o,
    input  logic [63:0]               fetch_data_i,
    input  logic                      br_take_i,
    input  logic [ADDR_W-1:0]         br_tgt_i,
    input  logic [IDX_W-1:0]          up_wr_idx_i,
    input  logic [IDX_W-1:0]          lo_wr_idx_i,
    input  logic [RD_PORTS*IDX_W-1:0] lo_rd_idx_i,
    output logic                      up_valid_o,
    output logic                      lo_valid_o,
    output logic                      lo_wr_kill_o,
    output logic [RD_PORTS-1:0]       lo_rd_old_o,
    output logic                      imm_load_o,
    output logic [31:0]               imm_data_o,
    output logic                      irq_o,
    output logic [2:0]                status_o
);

    localparam logic [ADDR_W-1:0] PAIR_BYTES = ADDR_W'(8);

    useq_state_e       state_q, state_n;
    logic [ADDR_W-1:0] pc_q;
    logic              run_q, dbg_q, trap_q, irq_q;
    logic              issue, launch;
    up_flags_t         flags;
    logic              dbg_hit, trap_hit;
    logic              redirect;
    logic [ADDR_W-1:0] redirect_pc;
    logic              pend_next;
    logic              expire;

    // ---------------- state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // ---------------- transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_n = ST_RUN;
            ST_RUN:   if (expire)  state_n = pend_next ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // ---------------- per-state outputs
    always_comb begin
        issue  = 1'b0;
        launch = 1'b0;
        unique case (state_q)
            ST_IDLE:  launch = start_i;
            ST_RUN:   issue  = 1'b1;
            ST_DRAIN: issue  = 1'b1;
            default:  issue  = 1'b0;
        endcase
    end

    useq_flag_decode u_flags (
        .up_word  (fetch_data_i[63:32]),
        .issue    (issue),
        .dbg_en   (dbg_en_i),
        .trap_en  (trap_en_i),
        .flags    (flags),
        .dbg_hit  (dbg_hit),
        .trap_hit (trap_hit)
    );

    useq_slot_check #(.IDX_W(IDX_W), .RD_PORTS(RD_PORTS)) u_slots (
        .issue      (issue),
        .imm        (flags.imm),
        .up_wr_idx  (up_wr_idx_i),
        .lo_wr_idx  (lo_wr_idx_i),
        .lo_rd_idx  (lo_rd_idx_i),
        .lo_valid   (lo_valid_o),
        .lo_wr_kill (lo_wr_kill_o),
        .lo_rd_old  (lo_rd_old_o)
    );

    useq_branch_ctl #(.ADDR_W(ADDR_W)) u_branch (
        .clk         (clk),
        .rst         (rst),
        .clr         (launch),
        .issue       (issue),
        .take        (br_take_i & lo_valid_o),
        .tgt         (br_tgt_i),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .pend_next   (pend_next)
    );

    useq_end_ctl u_end (
        .clk    (clk),
        .rst    (rst),
        .clr    (launch),
        .issue  (issue),
        .fin    (flags.fin),
        .halt   (dbg_hit | trap_hit),
        .expire (expire)
    );

    // ---------------- program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (launch) begin
            pc_q <= start_pc_i & PC_MASK;
        end else if (issue) begin
            pc_q <= redirect ? (redirect_pc & PC_MASK)
                             : ((pc_q + PAIR_BYTES) & PC_MASK);
        end
    end

    // ---------------- status and interrupt
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            dbg_q  <= 1'b0;
            trap_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= dbg_hit | trap_hit;
            if (launch) begin
                run_q  <= 1'b1;
                dbg_q  <= 1'b0;
                trap_q <= 1'b0;
            end else begin
                if (expire)   run_q  <= 1'b0;
                if (dbg_hit)  dbg_q  <= 1'b1;
                if (trap_hit) trap_q <= 1'b1;
            end
        end
    end

    assign fetch_addr_o        = pc_q;
    assign up_valid_o          = issue;
    assign imm_load_o          = issue & flags.imm;
    assign imm_data_o          = fetch_data_i[31:0];
    assign irq_o               = irq_q;
    assign status_o[STAT_RUN]  = run_q;
    assign status_o[STAT_DBG]  = dbg_q;
    assign status_o[STAT_TRAP] = trap_q;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
    parameter int unsigned       ADDR_W  = 14,
    parameter logic [ADDR_W-1:0] PC_MASK = {{(ADDR_W-3){1'b1}}, 3'b000}
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              redirect,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              lo_valid,
    input logic              lo_kill,
    input logic              imm_load,
    input logic              irq,
    input logic [2:0]        status
);

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        up_valid && $past(up_valid) && !$past(redirect)
        |-> fetch_addr == (($past(fetch_addr) + ADDR_W'(8)) & PC_MASK)); // R2

    AST_BRANCH_LAND: assert property (@(posedge clk) disable iff (rst)
        $past(redirect) && up_valid
        |-> fetch_addr == ($past(redirect_pc) & PC_MASK)); // R7

    AST_IMM_NO_LOWER: assert property (@(posedge clk) disable iff (rst)
        imm_load |-> up_valid && !lo_valid); // R6

    AST_KILL_WITH_LOWER: assert property (@(posedge clk) disable iff (rst)
        lo_kill |-> lo_valid); // R9

    AST_RUN_ISSUES: assert property (@(posedge clk) disable iff (rst)
        status[0] |-> up_valid); // R1

    AST_DRAIN_ONCE: assert property (@(posedge clk) disable iff (rst)
        up_valid && !status[0] |=> !up_valid); // R11

    AST_IRQ_STOPS: assert property (@(posedge clk) disable iff (rst)
        irq |-> !status[0] && (status[1] || status[2])); // R4

endmodule

bind useq_ctrl useq_ctrl_chk #(.ADDR_W(ADDR_W), .PC_MASK(PC_MASK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .up_valid    (up_valid_o),
    .fetch_addr  (fetch_addr_o),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .lo_valid    (lo_valid_o),
    .lo_kill     (lo_wr_kill_o),
    .imm_load    (imm_load_o),
    .irq         (irq_o),
    .status      (status_o)
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam logic [AW-1:0] MASK = 8'hF8;

    typedef struct packed {
        logic [4:0] uw;
        logic [4:0] lw;
        logic [4:0] r0;
        logic [4:0] r1;
        logic       imm;
        logic [4:0] exp;   // {lo_valid, kill, old1, old0, imm_load}
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd3,  5'd4,  5'd5,  5'd6,  1'b0, 5'b10000},
        '{5'd7,  5'd7,  5'd1,  5'd2,  1'b0, 5'b11000},
        '{5'd9,  5'd1,  5'd9,  5'd2,  1'b0, 5'b10010},
        '{5'd9,  5'd2,  5'd1,  5'd9,  1'b0, 5'b10100},
        '{5'd0,  5'd0,  5'd0,  5'd0,  1'b0, 5'b10000},
        '{5'd12, 5'd12, 5'd12, 5'd12, 1'b0, 5'b11110},
        '{5'd5,  5'd5,  5'd5,  5'd5,  1'b1, 5'b00001},
        '{5'd4,  5'd8,  5'd4,  5'd8,  1'b0, 5'b10010}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_pc = '0;
    logic          dbg_en = 1'b0;
    logic          trap_en = 1'b0;
    logic [AW-1:0] fetch_addr;
    logic [63:0]   fetch_data;
    logic          up_valid, lo_valid, lo_kill, imm_load, irq;
    logic [1:0]    rd_old;
    logic [31:0]   imm_data;
    logic [2:0]    status;
    logic [63:0]   mem [32];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [AW-1:0] tr [64];
    logic          trun [64];
    logic [AW-1:0] ex [8];
    int ntr, nirq, irq_at;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fetch_data = mem[fetch_addr[7:3]];

    useq_ctrl #(.ADDR_W(AW), .PC_MASK(MASK), .IDX_W(5), .RD_PORTS(2)) u_useq_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .start_pc_i   (start_pc),
        .dbg_en_i     (dbg_en),
        .trap_en_i    (trap_en),
        .fetch_addr_o (fetch_addr),
        .fetch_data_i (fetch_data),
        .br_take_i    (fetch_data[31]),
        .br_tgt_i     (fetch_data[23:16]),
        .up_wr_idx_i  (fetch_data[36:32]),
        .lo_wr_idx_i  (fetch_data[4:0]),
        .lo_rd_idx_i  (fetch_data[14:5]),
        .up_valid_o   (up_valid),
        .lo_valid_o   (lo_valid),
        .lo_wr_kill_o (lo_kill),
        .lo_rd_old_o  (rd_old),
        .imm_load_o   (imm_load),
        .imm_data_o   (imm_data),
        .irq_o        (irq),
        .status_o     (status)
    );

    function automatic logic [31:0] up_w(bit i, bit e, bit d, bit t, logic [4:0] w);
        return {i, e, 1'b0, d, t, 22'd0, w};
    endfunction

    function automatic logic [31:0] lo_w(bit br, logic [7:0] tgt, logic [4:0] r1,
                                         logic [4:0] r0, logic [4:0] lw);
        return {br, 7'd0, tgt, 1'b0, r1, r0, lw};
    endfunction

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 32; k++) mem[k] = 64'd0;
    endtask

    task automatic run_prog(input logic [AW-1:0] spc, input int poke);
        ntr = 0; nirq = 0; irq_at = -1;
        @(negedge clk);
        start_pc = spc;
        start = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c == poke) begin
                start = 1'b1;
                start_pc = 8'h80;
            end
            if (irq) begin
                nirq++;
                irq_at = ntr;
            end
            if (up_valid && ntr < 64) begin
                tr[ntr] = fetch_addr;
                trun[ntr] = status[0];
                ntr++;
            end
        end
        start = 1'b0;
    endtask

    task automatic chk_trace(input string req, input int n);
        chk_eq(req, ntr, n);
        for (int k = 0; k < n && k < ntr; k++) chk_eq(req, tr[k], ex[k]);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk_eq("R12 up_valid", up_valid, 0);
        chk_eq("R12 lo_valid", lo_valid, 0);
        chk_eq("R12 imm_load", imm_load, 0);
        chk_eq("R12 irq", irq, 0);
        chk_eq("R12 status", status, 0);
        chk_eq("R12 fetch_addr", fetch_addr, 0);

        // table walk: slot conflicts, immediate pair (R9 R10 R6 R1)
        for (int i = 0; i < 8; i++)
            mem[i] = {up_w(VECS[i].imm, i == 6, 1'b0, 1'b0, VECS[i].uw),
                      lo_w(VECS[i].imm, 8'h80, VECS[i].r1, VECS[i].r0, VECS[i].lw)};
        @(negedge clk);
        start_pc = 8'h00;
        start = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk_eq("R1 issue", up_valid, 1);
            chk_eq("R1 sequential address", fetch_addr, i * 8);
            chk_eq("R6 lower valid", lo_valid, VECS[i].exp[4]);
            chk_eq("R9 write kill", lo_kill, VECS[i].exp[3]);
            chk_eq("R10 read old", rd_old, VECS[i].exp[2:1]);
            chk_eq("R6 imm load", imm_load, VECS[i].exp[0]);
            if (VECS[i].imm) chk_eq("R6 imm data", imm_data, mem[i][31:0]);
        end
        @(negedge clk);
        chk_eq("R3 stopped after end pair", up_valid, 0);
        chk_eq("R3 running clear", status, 0);

        // R3 end flag, R12 start ignored while running
        clear_mem();
        mem[2] = {up_w(0, 1, 0, 0, 5'd0), 32'd0};
        run_prog(8'h00, 1);
        ex = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h00, 8'h00, 8'h00, 8'h00};
        chk_trace("R3 end trace", 4);
        chk_eq("R12 running set by start", trun[0], 1);
        chk_eq("R3 running clear", status, 0);

        // R7 branch delay slot
        clear_mem();
        mem[1]  = {32'd0, lo_w(1, 8'h60, 0, 0, 0)};
        mem[13] = {up_w(0, 1, 0, 0, 5'd0), 32'd0};
        run_prog(8'h00, -1);
        ex = '{8'h00, 8'h08, 8'h10, 8'h60, 8'h68, 8'h70, 8'h00, 8'h00};
        chk_trace("R7 branch trace", 6);

        // R8 branch inside delay slot
        clear_mem();
        mem[0]  = {32'd0, lo_w(1, 8'h40, 0, 0, 0)};
        mem[1]  = {32'd0, lo_w(1, 8'hA0, 0, 0, 0)};
        mem[20] = {up_w(0, 1, 0, 0, 5'd0), 32'd0};
        run_prog(8'h00, -1);
        ex = '{8'h00, 8'h08, 8'h40, 8'h48, 8'hA0, 8'hA8, 8'h00, 8'h00};
        chk_trace("R8 nested branch trace", 6);

        // R4 debug enabled
        clear_mem();
        mem[1] = {up_w(0, 0, 1, 0, 5'd0), 32'd0};
        dbg_en = 1'b1;
        run_prog(8'h00, -1);
        ex = '{8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        chk_trace("R4 debug stop trace", 2);
        chk_eq("R4 irq count", nirq, 1);
        chk_eq("R4 irq timing", irq_at, 2);
        chk_eq("R4 status", status, 3'b010);

        // R4 debug disabled has no effect
        dbg_en = 1'b0;
        mem[3] = {up_w(0, 1, 0, 0, 5'd0), 32'd0};
        run_prog(8'h00, -1);
        ex = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h20, 8'h00, 8'h00, 8'h00};
        chk_trace("R4 debug disabled trace", 5);
        chk_eq("R4 no irq when disabled", nirq, 0);
        chk_eq("R4 status when disabled", status, 3'b000);

        // R5 trap enabled, debug flag in same pair but disabled
        clear_mem();
        mem[0] = {up_w(0, 0, 1, 1, 5'd0), 32'd0};
        trap_en = 1'b1;
        run_prog(8'h00, -1);
        ex = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        chk_trace("R5 trap stop trace", 1);
        chk_eq("R5 irq count", nirq, 1);
        chk_eq("R5 irq timing", irq_at, 1);
        chk_eq("R5 status", status, 3'b100);
        trap_en = 1'b0;

        // R2 wrap and masked start address
        clear_mem();
        mem[0] = {up_w(0, 1, 0, 0, 5'd0), 32'd0};
        run_prog(8'hF3, -1);
        ex = '{8'hF0, 8'hF8, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00};
        chk_trace("R2 wrap trace", 4);

        // R11 stop with branch pending
        clear_mem();
        mem[0] = {up_w(0, 1, 0, 0, 5'd0), 32'd0};
        mem[1] = {32'd0, lo_w(1, 8'h40, 0, 0, 0)};
        run_prog(8'h00, -1);
        ex = '{8'h00, 8'h08, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        chk_trace("R11 drain trace", 3);
        chk_eq("R11 drain pair runs with running clear", trun[2], 0);
        chk_eq("R11 running before drain", trun[1], 1);
        chk_eq("R11 idle after drain", status, 0);

        summary();
        $finish;
    end

endmodule